// File: doc/BRIEF.md
# Fixed-Point Sine and Cosine Evaluator

This block turns a signed fixed-point angle in radians into a signed fixed-point sine, or a cosine when the mode input is set. A start pulse captures the angle and the mode. The block then folds the angle into the interval from minus a quarter turn to plus a quarter turn, using odd symmetry and at most one subtraction of half a turn. Cosine is obtained by adding a quarter turn to the angle before the fold, so both functions share one datapath.

After the fold, a degree-7 odd polynomial is evaluated by Horner's scheme on the squared argument. One shared multiply-add unit is used for five consecutive cycles. A busy level spans the operation, and a one-cycle done pulse marks its end. The result and the error flag then stay unchanged until the next operation completes. An angle whose folded magnitude still lies outside the quarter-turn interval is flagged as out of range and gives a zero result.

The angle has 28 fractional bits. The result has 30 fractional bits. The polynomial coefficients are the Taylor terms 1, -1/6, 1/120 and -1/5040, each rounded to 30 fractional bits and held in a small constant table.

Top module: `sine_poly_eval`

## Requirements
- R1: While `rst` is high, and after it is released until the first start, `busy`, `done`, `range_err` and `result` are all zero.
- R2: When `start` is high at a clock edge while `busy` is low, `busy` is high from that edge on. If the angle is in range, `done` is high for the single cycle following the sixth later edge, and `busy` falls at that same edge. `done` and `busy` are never high together.
- R3: For an in-range angle, `result` (30 fractional bits) lies within 3.0e-4 of the true sine of the angle (28 fractional bits), and its magnitude never exceeds 1 + 1/1024.
- R4: In sine mode, the result for a negated angle is exactly the bitwise two's-complement negation of the result for the original angle.
- R5: If the magnitude a of the angle is above Hq = 421657428, the value Pq = 843314857 (π·2^28) is subtracted and the sign of the output is flipped. The folded argument fed to the polynomial therefore never exceeds π/2 in magnitude.
- R6: Cosine mode (`cos_sel` = 1) adds Hq to the angle and then follows the sine path. Its result equals, bit for bit, the sine-mode result for the angle plus Hq.
- R7: If the magnitude of the angle (after the cosine offset, if any) is above 1264972285, `range_err` is 1 and `result` is 0. `done` then comes one edge after the start edge instead of six. A magnitude of exactly 1264972285 is in range.
- R8: `done` lasts exactly one cycle. `result` and `range_err` change only at the edge that raises `done`, and hold their values until the next completion.
- R9: A `start` pulse while `busy` is high is ignored. It neither restarts nor alters the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation when the block is not busy |
| cos_sel | input | 1 | 1 selects cosine, 0 selects sine; captured with start |
| angle | input | 32 | Signed angle in radians, 28 fractional bits |
| busy | output | 1 | High while an operation is in flight |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Folded angle outside the quarter-turn interval |
| result | output | 32 | Signed sine or cosine, 30 fractional bits |

## Verification
The hardest cases to reach are those where the folding thresholds are hit exactly. One is the last in-range angle, 1264972285, and its neighbour one step above it. The other is the same limit reached through the cosine offset, where the angle Pq lands exactly on the limit after Hq is added. The stimulus applies these exact codes in both modes, and also a start pulse issued in the middle of an operation with an out-of-range angle that must have no effect. Exact bitwise pairings (negated angles, and cosine against the sine of the offset angle) complement the tolerance comparison that runs against a real-valued model on every clock.

// File: rtl/sine_pkg.sv
package sine_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FOLD = 2'd1,
        PH_MUL  = 2'd2
    } phase_e;

    localparam real PI_R = 3.14159265358979323846;

    // Nearest fixed-point code of a real value with the given fractional bits
    function automatic longint fixq(input real v, input int frac);
        return longint'(v * (2.0 ** frac));
    endfunction

endpackage

// File: rtl/sine_arg_fold.sv
module sine_arg_fold
    import sine_pkg::*;
#(
    parameter int ANG_W    = 32,
    parameter int ANG_FRAC = 28,
    parameter int RES_FRAC = 30,
    parameter int IW       = 34
) (
    input  logic signed [ANG_W-1:0] angle,
    input  logic                    cos_sel,
    output logic signed [IW-1:0]    x_fold,
    output logic                    negate,
    output logic                    range_err
);
    localparam int SW = ANG_W + 2;
    localparam int SH = RES_FRAC - ANG_FRAC;
    localparam logic signed [SW-1:0] HQ  = SW'(fixq(PI_R / 2.0, ANG_FRAC));
    localparam logic signed [SW-1:0] PQ  = SW'(fixq(PI_R, ANG_FRAC));
    localparam logic signed [SW-1:0] LIM = PQ + HQ;

    logic signed [SW-1:0] a_d;
    logic signed [SW-1:0] mag_d;
    logic signed [SW-1:0] red_d;
    logic                 neg_in_d;
    logic                 big_d;

    always_comb begin
        a_d       = SW'(angle) + (cos_sel ? HQ : '0);
        neg_in_d  = a_d[SW-1];
        mag_d     = neg_in_d ? -a_d : a_d;
        big_d     = (mag_d > HQ);
        red_d     = big_d ? (mag_d - PQ) : mag_d;
        range_err = (mag_d > LIM);
        negate    = neg_in_d ^ big_d;
        x_fold    = IW'(red_d) <<< SH;
    end

endmodule

// File: rtl/sine_mul_add.sv
module sine_mul_add #(
    parameter int IW   = 34,
    parameter int FRAC = 30
) (
    input  logic signed [IW-1:0] op_a,
    input  logic signed [IW-1:0] op_b,
    input  logic signed [IW-1:0] op_c,
    output logic signed [IW-1:0] sum
);
    localparam int PW = 2 * IW;

    logic signed [PW-1:0] prod_d;

    always_comb begin
        prod_d = PW'(op_a) * PW'(op_b);
        sum    = IW'(prod_d >>> FRAC) + op_c;
    end

endmodule

// File: rtl/sine_poly_eval.sv
module sine_poly_eval
    import sine_pkg::*;
#(
    parameter int ANG_W    = 32,
    parameter int ANG_FRAC = 28,
    parameter int RES_W    = 32,
    parameter int RES_FRAC = 30
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    cos_sel,
    input  logic signed [ANG_W-1:0] angle,
    output logic                    busy,
    output logic                    done,
    output logic                    range_err,
    output logic signed [RES_W-1:0] result
);
    localparam int IW    = RES_FRAC + 4;
    localparam int DEG   = 7;
    localparam int NCOEF = (DEG + 1) / 2;
    localparam int STEPS = NCOEF + 1;
    localparam int STW   = $clog2(STEPS);

    // Odd Taylor terms, lowest power first
    localparam logic signed [IW-1:0] COEF [NCOEF] = '{
        IW'(fixq(1.0,           RES_FRAC)),
        IW'(fixq(-1.0 / 6.0,    RES_FRAC)),
        IW'(fixq(1.0 / 120.0,   RES_FRAC)),
        IW'(fixq(-1.0 / 5040.0, RES_FRAC))
    };

    localparam logic signed [IW-1:0]    X_LIM   = IW'(fixq(PI_R / 2.0, RES_FRAC)) + IW'(8);
    localparam logic signed [RES_W-1:0] OUT_LIM = RES_W'(fixq(1.0 + 1.0 / 1024.0, RES_FRAC));

    typedef struct packed {
        phase_e                  phase;
        logic [STW-1:0]          step;
        logic signed [ANG_W-1:0] angle;
        logic                    cos_sel;
        logic signed [IW-1:0]    x;
        logic signed [IW-1:0]    x2;
        logic signed [IW-1:0]    acc;
        logic                    neg;
        logic                    busy;
        logic                    done;
        logic                    err;
        logic signed [RES_W-1:0] result;
    } seq_t;

    seq_t seq_d, seq_q;

    logic signed [IW-1:0] fold_x;
    logic                 fold_neg;
    logic                 fold_err;
    logic signed [IW-1:0] mul_a, mul_b, mul_c, mul_y;

    sine_arg_fold #(
        .ANG_W   (ANG_W),
        .ANG_FRAC(ANG_FRAC),
        .RES_FRAC(RES_FRAC),
        .IW      (IW)
    ) u_fold (
        .angle    (seq_q.angle),
        .cos_sel  (seq_q.cos_sel),
        .x_fold   (fold_x),
        .negate   (fold_neg),
        .range_err(fold_err)
    );

    sine_mul_add #(
        .IW  (IW),
        .FRAC(RES_FRAC)
    ) u_mac (
        .op_a(mul_a),
        .op_b(mul_b),
        .op_c(mul_c),
        .sum (mul_y)
    );

    // Operand selection for the shared multiply-add
    always_comb begin
        mul_a = seq_q.acc;
        mul_b = seq_q.x2;
        mul_c = '0;
        if (seq_q.step == STW'(0)) begin
            mul_a = seq_q.x;
            mul_b = seq_q.x;
        end else if (seq_q.step == STW'(1)) begin
            mul_a = COEF[3];
            mul_c = COEF[2];
        end else if (seq_q.step == STW'(2)) begin
            mul_c = COEF[1];
        end else if (seq_q.step == STW'(3)) begin
            mul_c = COEF[0];
        end else begin
            mul_b = seq_q.x;
        end
    end

    // Next-state computation
    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (start) begin
                    seq_d.phase   = PH_FOLD;
                    seq_d.angle   = angle;
                    seq_d.cos_sel = cos_sel;
                    seq_d.busy    = 1'b1;
                    seq_d.step    = '0;
                end
            end
            PH_FOLD: begin
                if (fold_err) begin
                    seq_d.phase  = PH_IDLE;
                    seq_d.result = '0;
                    seq_d.err    = 1'b1;
                    seq_d.done   = 1'b1;
                    seq_d.busy   = 1'b0;
                end else begin
                    seq_d.phase = PH_MUL;
                    seq_d.x     = fold_x;
                    seq_d.neg   = fold_neg;
                    seq_d.step  = '0;
                end
            end
            PH_MUL: begin
                seq_d.step = seq_q.step + STW'(1);
                if (seq_q.step == STW'(0)) begin
                    seq_d.x2 = mul_y;
                end else begin
                    seq_d.acc = mul_y;
                end
                if (seq_q.step == STW'(STEPS - 1)) begin
                    seq_d.phase  = PH_IDLE;
                    seq_d.result = seq_q.neg ? -RES_W'(mul_y) : RES_W'(mul_y);
                    seq_d.err    = 1'b0;
                    seq_d.done   = 1'b1;
                    seq_d.busy   = 1'b0;
                end
            end
            default: begin
                seq_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = seq_q.busy;
    assign done      = seq_q.done;
    assign range_err = seq_q.err;
    assign result    = seq_q.result;

    // Checks on the sequencer and the fold output
    assert_accept_start_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_rise_needs_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(start) && !$past(busy)));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(range_err)));
    assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (done && range_err) |-> (result == '0));
    assert_fold_range_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_MUL && seq_q.step == STW'(0)) |->
        (seq_q.x <= X_LIM && seq_q.x >= -X_LIM));
    assert_unit_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !range_err) |-> (result <= OUT_LIM && result >= -OUT_LIM));

endmodule

// File: tb/test_sine_poly_eval.sv
module test_sine_poly_eval;

    localparam longint HQ_I  = 421657428;
    localparam longint LIM_I = 1264972285;
    localparam real    TOL   = 3.0e-4 * 1073741824.0;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic               cos_sel = 1'b0;
    logic signed [31:0] angle = '0;
    logic               busy;
    logic               done;
    logic               range_err;
    logic signed [31:0] result;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sine_poly_eval i_sine_poly_eval (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cos_sel  (cos_sel),
        .angle    (angle),
        .busy     (busy),
        .done     (done),
        .range_err(range_err),
        .result   (result)
    );

    task automatic chk_int(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_tol(input string tag, input longint act, input real exp_v);
        real want;
        real diff;
        want = exp_v * 1073741824.0;
        diff = real'(act) - want;
        if (diff < 0.0) diff = -diff;
        n_cmp++;
        if (diff > TOL) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0.1f", tag, act, want);
        end
    endtask

    // Behavioural expectation from the requirement text
    task automatic predict(input logic signed [31:0] ang, input logic cm,
                           output bit e, output real v);
        longint a;
        longint m;
        a = longint'(ang) + (cm ? HQ_I : 64'sd0);
        m = (a < 0) ? -a : a;
        e = (m > LIM_I);
        v = $sin(real'(a) / 268435456.0);
    endtask

    // Cycle model: busy/done timing and the expected outputs
    bit     m_busy = 0, m_done = 0, m_err = 0, m_tol = 0;
    int     m_left = 0;
    real    m_val = 0.0;
    bit     p_err;
    real    p_val;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_err = 0; m_tol = 0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    m_err  = p_err;
                    m_tol  = !p_err;
                    m_val  = p_val;
                end
            end else if (start) begin
                predict(angle, cos_sel, p_err, p_val);
                m_busy = 1;
                m_left = p_err ? 1 : 6;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk_int("R2 busy", busy, m_busy);
            chk_int("R8 done", done, m_done);
            chk_int("R7 range_err", range_err, m_err);
            if (m_tol) chk_tol("R3 result", result, m_val);
            else       chk_int("R7 result", result, 0);
        end
    end

    task automatic run(input int ang, input bit cm, output int res);
        @(negedge clk);
        angle = ang; cos_sel = cm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        res = result;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int r1, r2;
        repeat (3) @(negedge clk);
        chk_int("R1 busy", busy, 0);
        chk_int("R1 done", done, 0);
        chk_int("R1 range_err", range_err, 0);
        chk_int("R1 result", result, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk_int("R1 result after release", result, 0);

        // Main sine points
        run(0, 0, r1);           chk_int("R3 sin0", r1, 0);
        run(134217728, 0, r1);   chk_tol("R3 sin0.5", r1, $sin(0.5));
        run(421657428, 0, r1);   chk_tol("R3 sin quarter", r1, 1.0);
        run(-268435456, 0, r1);  chk_tol("R3 sin-1", r1, $sin(-1.0));
        run(536870912, 0, r1);   chk_tol("R5 sin2", r1, $sin(2.0));
        run(1073741824, 0, r1);  chk_tol("R5 sin4", r1, $sin(4.0));
        run(-671088640, 0, r1);  chk_tol("R5 sin-2.5", r1, $sin(-2.5));

        // Odd symmetry, exact
        for (int k = 1; k <= 6; k++) begin
            run(k * 190000000, 0, r1);
            run(-k * 190000000, 0, r2);
            chk_int("R4 negation", r2, -r1);
        end

        // Cosine equals sine of offset angle, exact
        for (int k = -3; k <= 3; k++) begin
            run(k * 250000000, 1, r1);
            run(k * 250000000 + 421657428, 0, r2);
            chk_int("R6 cos offset", r1, r2);
        end
        run(0, 1, r1); chk_tol("R6 cos0", r1, 1.0);

        // Range limits
        run(1264972285, 0, r1);  chk_int("R7 limit ok", range_err, 0);
        run(1264972286, 0, r1);  chk_int("R7 above limit", range_err, 1);
        chk_int("R7 zero result", r1, 0);
        run(-1264972286, 0, r1); chk_int("R7 below limit", range_err, 1);
        run(2000000000, 0, r1);  chk_int("R7 far", range_err, 1);
        run(843314857, 1, r1);   chk_int("R7 cos limit ok", range_err, 0);
        run(843314858, 1, r1);   chk_int("R7 cos above", range_err, 1);
        run(-1700000000, 1, r1); chk_int("R7 cos far", range_err, 1);

        // Start while busy is ignored
        @(negedge clk);
        angle = 300000000; cos_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        angle = 2100000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk_int("R9 no error from ignored start", range_err, 0);
        chk_tol("R9 first angle kept", result, $sin(300000000.0 / 268435456.0));

        // Hold after completion
        r1 = result;
        repeat (5) @(negedge clk);
        chk_int("R8 done low", done, 0);
        chk_int("R8 result held", result, r1);

        // Back-to-back with start held through done
        @(negedge clk);
        angle = 700000000; cos_sel = 1'b1; start = 1'b1;
        repeat (12) @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);

        // Sweeps
        for (int k = -20; k <= 20; k++) run(k * 60000000, 0, r1);
        for (int k = -20; k <= 20; k++) run(k * 40000000, 1, r1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule